// File: doc/BRIEF.md
# Stochastic Bitstream Scaled Adder

This block adds two unsigned fractions in the stochastic domain. In this domain a value is carried by a serial bitstream. The share of ones in the stream gives its size. Each W-bit operand becomes a stream through a comparator. The comparator emits a one on every cycle where the operand is strictly greater than a pseudo-random sample. A 2-to-1 selector merges the two operand streams, one bit per clock. A third random stream steers the selector, and that stream is one about half of the time. The merged stream therefore has a one-probability of P(a)·(1−P(s)) + P(b)·P(s). With P(s) near one half, this reduces to (P(a)+P(b))/2.

The result is the half sum (a+b)/2 and not the true sum. A start pulse opens a window of exactly 2^W clocks. During the window a counter totals the ones on the merged stream. At the end of the window the total is reported as a W-bit fraction, together with a one-cycle done pulse. The merged stream is also brought out on a pin, so a consumer can observe each bit that is counted.

Top module: `sc_scaled_adder`

## Requirements
- R1: While reset is high, and in the first cycle after it, done_o and stream_o are 0 and sum_o is 0.
- R2: An operand stream bit is 1 only when the operand is strictly greater than the random sample of that cycle. An operand of 0 therefore never produces a one.
- R3: The merged bit takes the A stream when the select bit is 0 and the B stream when it is 1. The select bit is the top bit of an independent third generator, so operands 255 and 0 give a result near 127.
- R4: A start pulse sampled while idle opens a window of exactly 2^W counting clocks. done_o rises in the cycle after the 2^W-th clock edge that follows the edge at which start was sampled.
- R5: done_o stays high for exactly one cycle. sum_o then holds its value until the next window ends.
- R6: sum_o is the count of ones in the window. A count of 2^W saturates to 2^W−1. The result lies within 24 LSB of (a+b)/2, which is half of the true sum, not the sum itself.
- R7: A start pulse that arrives while a window is running has no effect. The window still ends at the time set by the first start, and no second done follows.
- R8: stream_o carries the merged bit on every counting cycle. The number of ones seen on stream_o over the window equals sum_o whenever that number is below 2^W.
- R9: stream_o is 0 whenever no window is running.
- R10: Reset reloads every generator seed, and the generators advance only inside a window. The same operands run first after each reset therefore give identical results.
- R11: Both operands at 0 give exactly 0. Both operands at full scale (2^W−1) give at least 2^W−6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens a counting window when idle |
| op_a_i | input | W | First operand, unsigned fraction of 2^W |
| op_b_i | input | W | Second operand, unsigned fraction of 2^W |
| sum_o | output | W | Half sum of the operands as a fraction of 2^W |
| done_o | output | 1 | One-cycle pulse when sum_o is updated |
| stream_o | output | 1 | Merged output bitstream, 0 when idle |

## Verification
The bench holds start_i high across a single clock edge and names that edge zero. The stream bit that drives each count is read at the falling edge after edges 0 through 2^W−1, which gives exactly 2^W samples. done_o and sum_o are due after rising edge 2^W. The bench counts falling edges after edge zero and requires done on falling edge 2^W, and on no earlier one. sum_o is checked at that same edge, checked again a few cycles later to confirm that it holds, and done_o is checked low on the next falling edge. A start pulse inserted mid-window must leave that latency unchanged.

// File: rtl/sc_pkg.sv
package sc_pkg;

    // Feedback mask for a right-shifting Galois generator of maximal length.
    function automatic logic [15:0] lfsr_mask(input int unsigned width);
        case (width)
            4:       return 16'h000C;
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            8:       return 16'h00B8;
            9:       return 16'h0110;
            10:      return 16'h0240;
            11:      return 16'h0500;
            12:      return 16'h0E08;
            13:      return 16'h1C80;
            14:      return 16'h3802;
            15:      return 16'h6000;
            default: return 16'hD008;
        endcase
    endfunction

    // Distinct non-zero seed for generator number idx.
    function automatic logic [15:0] lfsr_seed(input int unsigned idx, input int unsigned width);
        logic [31:0] raw;
        logic [15:0] cut;
        raw = (idx + 32'd1) * 32'h0000_9E37 + 32'h0000_0A5B;
        cut = raw[15:0] & ((16'h1 << width) - 16'h1);
        if (cut == 16'h0) begin
            cut = 16'h1;
        end
        return cut;
    endfunction

    localparam int unsigned NUM_GEN = 3;
    localparam int unsigned GEN_A   = 0;
    localparam int unsigned GEN_B   = 1;
    localparam int unsigned GEN_SEL = 2;

endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
    parameter int unsigned W    = 8,
    parameter logic [15:0] SEED = 16'h0001
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         adv_i,
    output logic [W-1:0] rnd_o
);
    localparam logic [W-1:0] MASK  = W'(sc_pkg::lfsr_mask(W));
    localparam logic [W-1:0] START = W'(SEED);

    typedef struct packed {
        logic [W-1:0] st;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d = gen_q;
        if (adv_i) begin
            gen_d.st = (gen_q.st >> 1) ^ (gen_q.st[0] ? MASK : '0);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gen_q.st <= START;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign rnd_o = gen_q.st;

endmodule

// File: rtl/sc_window_counter.sv
module sc_window_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         start_i,
    input  logic         bit_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W:0]   ones_o,
    output logic [W-1:0] result_o
);
    localparam logic [W-1:0] LAST_CYC = '1;

    typedef struct packed {
        logic         busy;
        logic         done;
        logic [W-1:0] cyc;
        logic [W:0]   ones;
        logic [W-1:0] result;
    } win_t;

    win_t win_d, win_q;
    logic [W:0] total;

    always_comb begin
        win_d      = win_q;
        win_d.done = 1'b0;
        total      = win_q.ones + (W+1)'(bit_i);
        if (!win_q.busy) begin
            if (start_i) begin
                win_d.busy = 1'b1;
                win_d.cyc  = '0;
                win_d.ones = '0;
            end
        end else begin
            win_d.ones = total;
            win_d.cyc  = win_q.cyc + W'(1);
            if (win_q.cyc == LAST_CYC) begin
                win_d.busy   = 1'b0;
                win_d.done   = 1'b1;
                win_d.result = total[W] ? '1 : total[W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            win_q.busy   <= 1'b0;
            win_q.done   <= 1'b0;
            win_q.cyc    <= '0;
            win_q.ones   <= '0;
            win_q.result <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    assign busy_o   = win_q.busy;
    assign done_o   = win_q.done;
    assign ones_o   = win_q.ones;
    assign result_o = win_q.result;

endmodule

// File: rtl/sc_scaled_adder.sv
module sc_scaled_adder #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         start_i,
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    output logic [W-1:0] sum_o,
    output logic         done_o,
    output logic         stream_o
);
    localparam int unsigned NG = sc_pkg::NUM_GEN;

    logic [W-1:0] rnd [NG];
    logic [W-1:0] rnd_b_rev;
    logic         busy;
    logic         bit_a;
    logic         bit_b;
    logic         sel_bit;
    logic         mux_bit;
    logic [W:0]   ones;

    // Three generators with distinct seeds; all advance only inside a window.
    for (genvar g = 0; g < NG; g++) begin : g_gen
        sc_lfsr #(
            .W    (W),
            .SEED (sc_pkg::lfsr_seed(g, W))
        ) u_lfsr (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .adv_i (busy),
            .rnd_o (rnd[g])
        );
    end

    // Bit-reversed sample decorrelates the B comparator further.
    for (genvar k = 0; k < W; k++) begin : g_rev
        assign rnd_b_rev[k] = rnd[sc_pkg::GEN_B][W-1-k];
    end

    assign bit_a    = op_a_i > rnd[sc_pkg::GEN_A];
    assign bit_b    = op_b_i > rnd_b_rev;
    assign sel_bit  = rnd[sc_pkg::GEN_SEL][W-1];
    assign mux_bit  = sel_bit ? bit_b : bit_a;
    assign stream_o = busy & mux_bit;

    sc_window_counter #(
        .W (W)
    ) u_win (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .bit_i    (mux_bit),
        .busy_o   (busy),
        .done_o   (done_o),
        .ones_o   (ones),
        .result_o (sum_o)
    );

endmodule

// File: rtl/sc_scaled_adder_chk.sv
module sc_scaled_adder_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         start_i,
    input logic [W-1:0] op_a_i,
    input logic [W-1:0] sum_o,
    input logic         done_o,
    input logic         stream_o,
    input logic         busy,
    input logic         bit_a,
    input logic         bit_b,
    input logic         sel_bit,
    input logic [W:0]   ones
);
    localparam logic [W:0] FULL = (W+1)'(1) << W;

    logic past_rst_q = 1'b0;
    always_ff @(posedge clk_i) begin
        past_rst_q <= rst_i;
        if (past_rst_q) begin
            a_r1_reset_quiet : assert (!done_o && !stream_o && sum_o == '0)
                else $error("R1 outputs not quiet after reset");
        end
    end

    a_r5_done_single : assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    a_r4_done_ends_window : assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (!busy && $past(busy)));

    a_r9_idle_stream_low : assert property (@(posedge clk_i) disable iff (rst_i)
        !busy |-> !stream_o);

    a_r3_select_pick : assert property (@(posedge clk_i) disable iff (rst_i)
        busy |-> (stream_o == (sel_bit ? bit_b : bit_a)));

    a_r2_zero_operand : assert property (@(posedge clk_i) disable iff (rst_i)
        (op_a_i == '0) |-> !bit_a);

    a_r6_no_overflow : assert property (@(posedge clk_i) disable iff (rst_i)
        ones <= FULL);

    a_r7_start_ignored : assert property (@(posedge clk_i) disable iff (rst_i)
        (busy && start_i) |=> (busy || done_o));

endmodule

bind sc_scaled_adder sc_scaled_adder_chk #(.W(W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .start_i  (start_i),
    .op_a_i   (op_a_i),
    .sum_o    (sum_o),
    .done_o   (done_o),
    .stream_o (stream_o),
    .busy     (busy),
    .bit_a    (bit_a),
    .bit_b    (bit_b),
    .sel_bit  (sel_bit),
    .ones     (ones)
);

// File: tb/sc_scaled_adder_tb.sv
module sc_scaled_adder_tb;
    localparam int unsigned W   = 8;
    localparam int          WIN = 1 << W;
    localparam int          TOL = 24;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] sum;
    logic         done;
    logic         stream;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sc_scaled_adder #(.W(W)) u_dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .start_i  (start),
        .op_a_i   (op_a),
        .op_b_i   (op_b),
        .sum_o    (sum),
        .done_o   (done),
        .stream_o (stream)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int absdiff(input int x, input int y);
        return (x > y) ? x - y : y - x;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs one window; optionally pulses start again at falling edge ign_at.
    task automatic run(input int a, input int b, input int ign_at,
                       output int res, output int lat, output int seen);
        int c;
        op_a  = W'(a);
        op_b  = W'(b);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c     = 0;
        seen  = stream ? 1 : 0;
        while (!done && c < 4 * WIN) begin
            @(negedge clk);
            c++;
            start = (c == ign_at);
            if (c < WIN && stream) seen++;
        end
        start = 1'b0;
        lat   = c;
        res   = sum;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        chk(sum == '0, "R1 sum in reset", sum, 0);
        chk(stream == 1'b0, "R1/R9 stream in reset", stream, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && sum == '0, "R1 after reset", sum, 0);
    endtask

    task automatic t_zero();
        int r, l, s;
        run(0, 0, -1, r, l, s);
        chk(l == WIN, "R4 window length", l, WIN);
        chk(r == 0, "R11/R2 zero operands", r, 0);
        chk(s == 0, "R2 zero stream ones", s, 0);
    endtask

    task automatic t_full();
        int r, l, s;
        run(WIN - 1, WIN - 1, -1, r, l, s);
        chk(r >= WIN - 6, "R11 full scale", r, WIN - 1);
        chk(r <= WIN - 1, "R6 saturation bound", r, WIN - 1);
    endtask

    task automatic t_mid(input int a, input int b, input string tag);
        int r, l, s, e;
        e = (a + b) / 2;
        run(a, b, -1, r, l, s);
        chk(l == WIN, "R4 latency", l, WIN);
        chk(absdiff(r, e) <= TOL, tag, r, e);
        if (s < WIN) chk(s == r, "R8 stream ones match sum", s, r);
    endtask

    task automatic t_ignore();
        int r, l, s;
        run(100, 60, 100, r, l, s);
        chk(l == WIN, "R7 mid-window start ignored", l, WIN);
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", done, 0);
        repeat (20) begin
            @(negedge clk);
            if (done) break;
        end
        chk(done == 1'b0, "R7 no second done", done, 0);
        chk(sum == W'(r), "R5 sum holds", sum, r);
        chk(stream == 1'b0, "R9 idle stream low", stream, 0);
    endtask

    task automatic t_reseed();
        int r1, r2, r3, l, s;
        do_reset();
        run(90, 170, -1, r1, l, s);
        run(90, 170, -1, r2, l, s);
        do_reset();
        repeat (7) @(negedge clk);
        run(90, 170, -1, r3, l, s);
        chk(r3 == r1, "R10 reseed repeat", r3, r1);
        chk(absdiff(r2, 130) <= TOL, "R6 continued run", r2, 130);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_zero();
        t_full();
        t_mid(100, 60, "R6 half sum 100,60");
        t_mid(WIN - 1, 0, "R3 select balance 255,0");
        t_mid(0, 200, "R3 select balance 0,200");
        t_mid(200, 200, "R6 scaled not exact 200,200");
        t_ignore();
        t_reseed();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule